// File: doc/BRIEF.md
# Pipelined SPI ADC Command Decoder

This block is the target side of a serial multi-channel sampling converter. A host clocks 16-bit command words in, MSB first, one bit per rising clock edge while chip select is low, and releases chip select between words. Each complete word is decoded at its last bit. A manual-channel word picks the channel to sample and may rewrite a seven-bit configuration register. A GPIO-program word sets the four pin directions, an alarm-mode field and two pin-strap enables, or clears every register.

The sample picked by a word is taken at the end of that word. It is held for one more word and is shifted out during the word after that. Each result word carries the channel number in its top nibble and the sample left-aligned in the twelve bits below. When GPIO readback is on, the top nibble carries the four pin levels in place of the channel number. Sample values come from a per-channel input bus, and the four GPIO pins appear as separate input, output and enable bits.

Top module: `spi_adc_target`

## Requirements
- R1: While `cs_n` is low, each rising edge of `clk` shifts `mosi` in, MSB first. `miso` presents the current output word MSB first, changing after each edge, and is 0 while `cs_n` is high. Raising `cs_n` before the 16th bit drops the partial word, which then has no effect on any register or on the output pipeline.
- R2: A word whose bits 15:12 equal 4'b0001 is a manual-channel word. Its bits 10:7 select the channel for this word and for later words that select none.
- R3: In a manual-channel word, bit 11 set loads bits 6:0 into the configuration register. With bit 11 clear the configuration keeps its value.
- R4: Configuration bits 3:0 drive `gpio_out`. Bit 5 drives `pwr_dn` and bit 6 drives `range_hi`.
- R5: A word whose bits 15:12 equal 4'b0100 programs the GPIO setup. Bits 3:0 go to `gpio_oe` (1 = output). Bits 6:4 go to `alarm_mode`. Bit 7 makes `gpio_in[2]` also assert `range_hi`, and bit 8 makes `gpio_in[3]` also assert `pwr_dn`. If bit 9 is set, every register (configuration, directions, alarm, strap enables, channel) is cleared instead.
- R6: The result word produced by frame k is shifted out during frame k+2. Words with any other top nibble change no register, but they still advance the pipeline and sample the last selected channel.
- R7: A result word holds the channel in bits 15:12 and the RES-bit sample in bits 11:12-RES. The bits below those are zero.
- R8: A channel number at or above NCH returns zero data.
- R9: If configuration bit 4 is set after a word has been decoded, that word's result carries the pin levels in bits 15:12. An output pin shows its driven level and an input pin shows `gpio_in`.
- R10: After reset all registers are zero, every pin is an input, and the first two result words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Command bit in |
| miso | output | 1 | Result bit out |
| samples | input | NCH*RES | Per-channel sample values, channel 0 in the low bits |
| gpio_in | input | 4 | GPIO pin levels seen from outside |
| gpio_out | output | 4 | GPIO drive levels |
| gpio_oe | output | 4 | GPIO output enables |
| range_hi | output | 1 | Doubled input range selected |
| pwr_dn | output | 1 | Power-down request |
| alarm_mode | output | 3 | Stored alarm-mode field |

## Verification
The bench builds the block with NCH=4 and RES=10. This size lets it sweep every 4-bit channel code: codes 0 to 3 return shifted data with two zero low bits, and codes 4 to 15 land on the zero-data path. Three sample patterns run through the full sweep, so each result is checked against the word sent two frames before it. With four pins, a single mixed direction pattern exercises both branches of the readback mux.

// File: rtl/spi_adc_target.sv
module spi_adc_target #(
  parameter int NCH = 16,
  parameter int RES = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               mosi,
  output logic               miso,
  input  logic [NCH*RES-1:0] samples,
  input  logic [3:0]         gpio_in,
  output logic [3:0]         gpio_out,
  output logic [3:0]         gpio_oe,
  output logic               range_hi,
  output logic               pwr_dn,
  output logic [2:0]         alarm_mode
);
  localparam int SH = 12 - RES;

  logic [14:0] rx;
  logic [3:0]  cnt;
  logic [15:0] s1, s2;
  logic [6:0]  cfg, cfg_n;
  logic [3:0]  dir, dir_n, chan, chan_n;
  logic [2:0]  alm, alm_n;
  logic        ren, ren_n, pen, pen_n;
  logic [RES-1:0] sa [16];

  wire [15:0] w      = {rx, mosi};
  wire        done   = !cs_n && cnt == 4'd15;
  wire        is_man = w[15:12] == 4'b0001;
  wire        is_gp  = w[15:12] == 4'b0100;

  for (genvar g = 0; g < 16; g++) begin : g_smp
    if (g < NCH) begin : g_on
      assign sa[g] = samples[g*RES +: RES];
    end else begin : g_off
      assign sa[g] = '0;
    end
  end

  always_comb begin
    cfg_n = cfg; dir_n = dir; chan_n = chan; alm_n = alm; ren_n = ren; pen_n = pen;
    if (is_man) begin
      chan_n = w[10:7];
      if (w[11]) cfg_n = w[6:0];
    end else if (is_gp) begin
      if (w[9]) begin
        cfg_n = '0; dir_n = '0; chan_n = '0; alm_n = '0; ren_n = 1'b0; pen_n = 1'b0;
      end else begin
        dir_n = w[3:0]; alm_n = w[6:4]; ren_n = w[7]; pen_n = w[8];
      end
    end
  end

  wire [3:0]  lv  = (dir_n & cfg_n[3:0]) | (~dir_n & gpio_in);
  wire [11:0] dat = 12'(sa[chan_n]) << SH;
  wire [15:0] res = {cfg_n[4] ? lv : chan_n, dat};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx <= '0; cnt <= '0; s1 <= '0; s2 <= '0;
      cfg <= '0; dir <= '0; chan <= '0; alm <= '0; ren <= 1'b0; pen <= 1'b0;
    end else begin
      if (cs_n) cnt <= '0;
      else begin
        rx  <= {rx[13:0], mosi};
        cnt <= cnt + 4'd1;
      end
      if (done) begin
        cfg <= cfg_n; dir <= dir_n; chan <= chan_n; alm <= alm_n; ren <= ren_n; pen <= pen_n;
        s1 <= res;
        s2 <= s1;
      end
    end
  end

  assign miso       = !cs_n && s2[4'd15 - cnt];
  assign gpio_out   = cfg[3:0];
  assign gpio_oe    = dir;
  assign alarm_mode = alm;
  assign range_hi   = cfg[6] | (ren & gpio_in[2]);
  assign pwr_dn     = cfg[5] | (pen & gpio_in[3]);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done && !(is_man && w[11]) && !(is_gp && w[9]) |=> $stable(gpio_out));
  p_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done && is_gp && !w[9] |=> gpio_oe == $past(w[3:0]));
  p_pipe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> s2 == $past(s1));
  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(s2) && $stable(gpio_oe));
  p_tag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done && is_man && !cfg_n[4] |=> s1[15:12] == $past(w[10:7]));
  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> cnt == 4'd0);
endmodule

// File: tb/sim_spi_adc_target.sv
module sim_spi_adc_target;
  localparam int NCH = 4;
  localparam int RES = 10;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  logic [NCH*RES-1:0] samples = '0;
  logic [3:0] gpio_in = '0, gpio_out, gpio_oe;
  logic range_hi, pwr_dn;
  logic [2:0] alarm_mode;

  int total = 0, bad = 0;
  logic [6:0] m_cfg = '0;
  logic [3:0] m_dir = '0, m_chan = '0;
  logic [2:0] m_alm = '0;
  logic m_ren = 1'b0, m_pen = 1'b0;
  logic [15:0] q1 = '0, q2 = '0;

  always #10 clk = ~clk;

  spi_adc_target #(.NCH(NCH), .RES(RES)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .samples(samples), .gpio_in(gpio_in), .gpio_out(gpio_out), .gpio_oe(gpio_oe),
    .range_hi(range_hi), .pwr_dn(pwr_dn), .alarm_mode(alarm_mode));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_outs(input string tag);
    chk({tag, " gpio_out R4"}, 32'(gpio_out), 32'(m_cfg[3:0]));
    chk({tag, " gpio_oe R5"}, 32'(gpio_oe), 32'(m_dir));
    chk({tag, " alarm R5"}, 32'(alarm_mode), 32'(m_alm));
    chk({tag, " range R4/R5"}, 32'(range_hi), 32'(m_cfg[6] | (m_ren & gpio_in[2])));
    chk({tag, " pwrdn R4/R5"}, 32'(pwr_dn), 32'(m_cfg[5] | (m_pen & gpio_in[3])));
  endtask

  task automatic xfer(input logic [15:0] cmd, input string tag);
    logic [15:0] got;
    logic [3:0] lv;
    logic [RES-1:0] d;
    @(negedge clk);
    cs_n = 1'b0;
    for (int i = 0; i < 16; i++) begin
      mosi = cmd[15-i];
      #1 got[15-i] = miso;
      @(negedge clk);
    end
    cs_n = 1'b1;
    mosi = 1'b0;
    chk({tag, " result"}, 32'(got), 32'(q2));
    if (cmd[15:12] == 4'b0001) begin
      m_chan = cmd[10:7];
      if (cmd[11]) m_cfg = cmd[6:0];
    end else if (cmd[15:12] == 4'b0100) begin
      if (cmd[9]) begin
        m_cfg = '0; m_dir = '0; m_chan = '0; m_alm = '0; m_ren = 1'b0; m_pen = 1'b0;
      end else begin
        m_dir = cmd[3:0]; m_alm = cmd[6:4]; m_ren = cmd[7]; m_pen = cmd[8];
      end
    end
    lv = (m_dir & m_cfg[3:0]) | (~m_dir & gpio_in);
    d = (m_chan < NCH) ? samples[m_chan*RES +: RES] : '0;
    q2 = q1;
    q1 = {m_cfg[4] ? lv : m_chan, d, 2'b00};
    chk_outs(tag);
  endtask

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 miso at reset", 32'(miso), 0);
    chk_outs("R10 reset");
    rst_n = 1'b1;
    samples = {10'd1023, 10'd512, 10'd3, 10'd777};
    xfer(16'h1000 | (16'd1 << 7), "R10 first word");
    xfer(16'h1000 | (16'd3 << 7), "R10 second word");
    for (int k = 0; k < 3; k++)
      for (int ch = 0; ch < 16; ch++) begin
        for (int c = 0; c < NCH; c++)
          samples[c*RES +: RES] = 10'((c * 37 + k * 301 + ch * 13) & 10'h3FF);
        xfer(16'h1000 | 16'(ch << 7), ch < NCH ? "R2 R7 sweep" : "R8 sweep");
      end
    xfer(16'h1000, "R6 flush");
    xfer(16'h1000, "R6 flush");
    chk("R1 idle miso", 32'(miso), 0);
    xfer(16'h1800 | 16'h0060 | (16'd2 << 7), "R3 write range+pd");
    xfer(16'h107F | (16'd1 << 7), "R3 write disabled");
    xfer(16'h2FFF, "R6 ignored word");
    xfer(16'h3A5F, "R6 ignored word2");
    xfer(16'h4005 | 16'h0050, "R5 dir+alarm");
    gpio_in = 4'b0110;
    xfer(16'h1800 | 16'h001A, "R9 readback on");
    xfer(16'h1800 | 16'h000A | (16'd2 << 7), "R9 readback off");
    gpio_in = 4'b1100;
    xfer(16'h1800, "R4 clear cfg");
    xfer(16'h4180, "R5 strap enables");
    gpio_in = 4'b0100;
    xfer(16'h1000, "R5 strap range only");
    xfer(16'h420F, "R5 reset all");
    xfer(16'h1000 | (16'd3 << 7), "R5 after reset");
    @(negedge clk);
    cs_n = 1'b0;
    for (int i = 0; i < 8; i++) begin
      mosi = i[0];
      @(negedge clk);
    end
    cs_n = 1'b1;
    mosi = 1'b0;
    chk_outs("R1 aborted frame");
    xfer(16'h1000 | (16'd2 << 7), "R1 after abort");
    xfer(16'h1000, "R1 after abort 2");
    xfer(16'h1000, "R6 drain");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule